// File: doc/BRIEF.md
# Direct-Conversion AM Receiver Front End

This block tunes one AM station out of a sampled RF stream that carries several stations at once. Each clock it takes one 10-bit offset-binary RF code and turns it back into a signed 16-bit sample. It then multiplies that sample by a local oscillator running at the wanted carrier frequency. The upper half of the product is a baseband stream, which leaves the block for an external decimating lowpass. That lowpass removes the sum-frequency term and the neighbouring stations.

The decimated samples arrive at the audio rate, roughly 48 kHz from a 50 MHz sample clock, and come with a valid strobe. A first-order DC blocker removes the offset that the wanted carrier leaves after mixing. The result leaves as audio with its own one-cycle valid pulse. The only control that selects a station is the oscillator tuning word.

Top module: `amRxFrontEnd`

## Requirements
- R1: While reset is asserted and after its release until the first update, `bbData` and `audioData` are 0 and `audioValid` is 0.
- R2: An RF code c is converted to the signed value (c − 512)·64. This is done by inverting the MSB and appending six zero LSBs, so code 512 gives 0, code 1023 gives 32704 and code 0 gives −32768.
- R3: The oscillator phase is a 32-bit accumulator that is 0 after reset and adds `tuneWord` modulo 2^32 at every clock edge. The oscillator sample latched at an edge is round(8191·sin(2π·i/256)), rounded half away from zero, where i is bits 31:24 of the phase before that edge's addition.
- R4: At each edge, bits 31:16 of the signed 32-bit product of the converted sample and the oscillator sample, both latched at the previous edge, appear on `bbData`. This gives two cycles of latency from `rfCode`.
- R5: A new `tuneWord` is used from the next edge onward and does not reset the accumulated phase, so retuning is phase-continuous.
- R6: At each edge with `decValid` high, the state updates as y ← x − xPrev + y − floor(y/256) and xPrev ← x, where x is `decData` and y is held wider than 16 bits. Without `decValid`, `audioData` holds its value.
- R7: `audioValid` is high for exactly the cycle that follows each edge at which `decValid` was high.
- R8: `audioData` is y clamped to the range −32768..32767.
- R9: A constant `decData` input settles: after enough updates, `audioData` stays within 0..255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rfCode | input | 10 | Offset-binary RF sample, one per clock |
| tuneWord | input | 32 | Oscillator phase increment per clock |
| decData | input | 16 | Signed decimated audio-rate sample |
| decValid | input | 1 | Strobe marking a valid `decData` |
| bbData | output | 16 | Signed baseband sample, one per clock |
| audioData | output | 16 | Signed DC-free audio sample |
| audioValid | output | 1 | One-cycle strobe for a new `audioData` |

## Verification
The bench builds the block with its default parameters: a 16-bit datapath, a 10-bit RF code, a 256-entry oscillator table with a peak of 8191, and a DC shift of 8. A tuning word of one quarter turn lands exactly on the zero and peak entries of the table, and a random tuning word walks through the whole table and through phase wraparound. With full-scale 16-bit steps into the DC blocker, the state passes the output range, so the clamp is exercised in one step. A shift of 8 lets the decay to the truncation floor finish within a few thousand audio updates.

// File: rtl/amRxPkg.sv
package amRxPkg;

  localparam real TwoPi = 6.283185307179586;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic dcLoad;   // advance the DC blocker by one audio sample
  } rxStrobes_t;

  // Oscillator table entry: amp * sin(2*pi*idx/2^tableBits), rounded half away from zero
  function automatic int loValue(int idx, int tableBits, int amp);
    real angle;
    real v;
    angle = TwoPi * real'(idx) / real'(1 << tableBits);
    v = real'(amp) * $sin(angle);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/amRxControl.sv
module amRxControl
  import amRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       decValid,
  output rxStrobes_t strobes,
  output logic       audioValid
);

  always_comb begin
    strobes.dcLoad = decValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) audioValid <= 1'b0;
    else       audioValid <= decValid;
  end

endmodule

// File: rtl/amRxDatapath.sv
module amRxDatapath
  import amRxPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RF_W       = 10,
  parameter int PHASE_W    = 32,
  parameter int TABLE_BITS = 8,
  parameter int LO_AMP     = 8191,
  parameter int DC_SHIFT   = 8,
  parameter int GUARD      = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rxStrobes_t               strobes,
  input  logic [RF_W-1:0]          rfCode,
  input  logic [PHASE_W-1:0]       tuneWord,
  input  logic signed [DATA_W-1:0] decData,
  output logic signed [DATA_W-1:0] bbData,
  output logic signed [DATA_W-1:0] audioData
);

  localparam int SHIFT_UP   = DATA_W - RF_W;
  localparam int TABLE_SIZE = 1 << TABLE_BITS;
  localparam int ACC_W      = DATA_W + GUARD;
  localparam int PROD_W     = 2 * DATA_W;
  localparam logic signed [ACC_W-1:0] SatHi = ACC_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SatLo = -SatHi - ACC_W'(1);

  // ---------------- offset binary to signed ----------------
  logic signed [DATA_W-1:0] rfSigned;
  if (SHIFT_UP > 0) begin : gWiden
    assign rfSigned = {~rfCode[RF_W-1], rfCode[RF_W-2:0], {SHIFT_UP{1'b0}}};
  end else begin : gNoWiden
    assign rfSigned = {~rfCode[RF_W-1], rfCode[RF_W-2:0]};
  end

  // ---------------- local oscillator ----------------
  logic signed [DATA_W-1:0] loTable [TABLE_SIZE];
  for (genvar k = 0; k < TABLE_SIZE; k++) begin : gLoTable
    assign loTable[k] = DATA_W'(loValue(k, TABLE_BITS, LO_AMP));
  end

  logic [PHASE_W-1:0]       phaseAcc;
  logic signed [DATA_W-1:0] rxReg;
  logic signed [DATA_W-1:0] loReg;
  logic signed [PROD_W-1:0] product;

  assign product = PROD_W'(rxReg) * PROD_W'(loReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      rxReg    <= '0;
      loReg    <= '0;
      bbData   <= '0;
    end else begin
      phaseAcc <= phaseAcc + tuneWord;
      rxReg    <= rfSigned;
      loReg    <= loTable[phaseAcc[PHASE_W-1 -: TABLE_BITS]];
      bbData   <= DATA_W'(product >>> DATA_W);
    end
  end

  // ---------------- DC blocker ----------------
  logic signed [DATA_W-1:0] xPrev;
  logic signed [ACC_W-1:0]  yAcc;
  logic signed [ACC_W-1:0]  yNext;
  logic signed [DATA_W-1:0] ySat;

  always_comb begin
    yNext = ACC_W'(decData) - ACC_W'(xPrev) + yAcc - (yAcc >>> DC_SHIFT);
    if (yNext > SatHi)      ySat = SatHi[DATA_W-1:0];
    else if (yNext < SatLo) ySat = SatLo[DATA_W-1:0];
    else                    ySat = yNext[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPrev     <= '0;
      yAcc      <= '0;
      audioData <= '0;
    end else if (strobes.dcLoad) begin
      xPrev     <= decData;
      yAcc      <= yNext;
      audioData <= ySat;
    end
  end

endmodule

// File: rtl/amRxFrontEnd.sv
module amRxFrontEnd
  import amRxPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RF_W       = 10,
  parameter int PHASE_W    = 32,
  parameter int TABLE_BITS = 8,
  parameter int LO_AMP     = 8191,
  parameter int DC_SHIFT   = 8,
  parameter int GUARD      = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [RF_W-1:0]          rfCode,
  input  logic [PHASE_W-1:0]       tuneWord,
  input  logic signed [DATA_W-1:0] decData,
  input  logic                     decValid,
  output logic signed [DATA_W-1:0] bbData,
  output logic signed [DATA_W-1:0] audioData,
  output logic                     audioValid
);

  rxStrobes_t strobes;

  amRxControl i_control (
    .clk        (clk),
    .rstN       (rstN),
    .decValid   (decValid),
    .strobes    (strobes),
    .audioValid (audioValid)
  );

  amRxDatapath #(
    .DATA_W     (DATA_W),
    .RF_W       (RF_W),
    .PHASE_W    (PHASE_W),
    .TABLE_BITS (TABLE_BITS),
    .LO_AMP     (LO_AMP),
    .DC_SHIFT   (DC_SHIFT),
    .GUARD      (GUARD)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rfCode    (rfCode),
    .tuneWord  (tuneWord),
    .decData   (decData),
    .bbData    (bbData),
    .audioData (audioData)
  );

endmodule

// File: rtl/amRxChecker.sv
module amRxChecker #(
  parameter int DATA_W = 16,
  parameter int RF_W   = 10
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [RF_W-1:0]          rfCode,
  input logic                     decValid,
  input logic signed [DATA_W-1:0] bbData,
  input logic signed [DATA_W-1:0] audioData,
  input logic                     audioValid
);

  localparam logic [RF_W-1:0] MidCode = RF_W'(1 << (RF_W - 1));

  // R7: every accepted audio sample is announced in the next cycle
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> audioValid);

  // R7: no announcement without an accepted sample
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> !audioValid);

  // R6: audio output holds between strobes
  assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> $stable(audioData));

  // R2 / R4: the mid-scale code converts to zero, so its product two edges later is zero
  assert_mid_code_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rfCode == MidCode) |=> ##1 (bbData == '0));

endmodule

bind amRxFrontEnd amRxChecker #(
  .DATA_W (DATA_W),
  .RF_W   (RF_W)
) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .rfCode     (rfCode),
  .decValid   (decValid),
  .bbData     (bbData),
  .audioData  (audioData),
  .audioValid (audioValid)
);

// File: tb/test_amRxFrontEnd.sv
`timescale 1ns/1ps
module test_amRxFrontEnd;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [9:0]        rfCode = 10'd512;
  logic [31:0]       tuneWord = 32'd0;
  logic signed [15:0] decData = 16'sd0;
  logic              decValid = 1'b0;
  logic signed [15:0] bbData;
  logic signed [15:0] audioData;
  logic              audioValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string bbTag = "R4";

  always #2 clk = ~clk;

  amRxFrontEnd i_amRxFrontEnd (
    .clk        (clk),
    .rstN       (rstN),
    .rfCode     (rfCode),
    .tuneWord   (tuneWord),
    .decData    (decData),
    .decValid   (decValid),
    .bbData     (bbData),
    .audioData  (audioData),
    .audioValid (audioValid)
  );

  // ---------------- reference model ----------------
  longint refSine [256];
  longint mPhase, mRx, mLo, mBb, mX, mY, mAud;
  logic   mVal;

  initial begin
    for (int k = 0; k < 256; k++)
      refSine[k] = longint'($floor(8191.0 * $sin(2.0 * 3.141592653589793 * k / 256.0) + 0.5));
  end

  function automatic longint clamp16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mRx = 0; mLo = 0; mBb = 0;
      mX = 0; mY = 0; mAud = 0; mVal = 1'b0;
    end else begin
      mBb = (mRx * mLo) >>> 16;
      mRx = (longint'(rfCode) - 512) * 64;
      mLo = refSine[(mPhase >> 24) & 255];
      mPhase = (mPhase + longint'(tuneWord)) & 64'hFFFF_FFFF;
      mVal = decValid;
      if (decValid) begin
        mY = longint'(decData) - mX + mY - (mY >>> 8);
        mX = longint'(decData);
        mAud = clamp16(mY);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (rstN) begin
      check(bbTag, longint'(bbData), mBb);
      check("R6/R8 audioData", longint'(audioData), mAud);
      check("R7 audioValid", longint'(audioValid), longint'(mVal));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 bbData", longint'(bbData), 0);
    check("R1 audioData", longint'(audioData), 0);
    check("R1 audioValid", longint'(audioValid), 0);
    rstN = 1'b1;

    // R2/R3/R4: quarter-turn tuning word, full-scale and mid codes
    bbTag = "R2/R3/R4";
    tuneWord = 32'h4000_0000;
    rfCode = 10'd1023;
    repeat (8) @(negedge clk);
    rfCode = 10'd0;
    repeat (8) @(negedge clk);
    rfCode = 10'd512;
    repeat (3) @(negedge clk);
    check("R2 mid code product", longint'(bbData), 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rfCode = 10'($urandom_range(1023));
    end

    // R5: retune several times without reset, phase carries on
    bbTag = "R5";
    tuneWord = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      rfCode = 10'($urandom_range(1023));
      if (i == 300) tuneWord = 32'hF0F0_1357;
      if (i == 450) tuneWord = 32'd0;
    end
    bbTag = "R4";

    // R8: full-scale step saturates
    pulseReset();
    decData = -16'sd32768; decValid = 1'b1;
    @(negedge clk);
    check("R8 lower bound exact", longint'(audioData), -32768);
    decData = 16'sd32767;
    @(negedge clk);
    check("R8 clamp high", longint'(audioData), 32767);
    check("R7 valid after strobe", longint'(audioValid), 1);
    decValid = 1'b0;

    // R6: inputs without strobe are ignored
    for (int i = 0; i < 5; i++) begin
      decData = 16'(i * 1111 - 3000);
      @(negedge clk);
    end
    check("R6 hold", longint'(audioData), 32767);
    check("R7 no valid", longint'(audioValid), 0);

    // R6/R7: sparse random audio samples
    for (int i = 0; i < 400; i++) begin
      decData = 16'($urandom_range(65535));
      decValid = ($urandom_range(3) == 0);
      @(negedge clk);
    end

    // R9: constant input decays to the truncation floor
    for (int i = 0; i < 3000; i++) begin
      decData = 16'sd10000; decValid = 1'b1;
      @(negedge clk);
      decValid = 1'b0;
      @(negedge clk);
    end
    checks++;
    if (audioData < 0 || audioData > 255) begin
      errors++;
      $display("FAIL R9 settled audio: actual %0d expected 0..255", audioData);
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule